// File: doc/BRIEF.md
# Drawing Engine Busy and Interrupt Controller

This block holds the control and status logic that sits beside a 2D drawing engine. It watches three status lines from the engine: whether the draw state machine is active, whether the command queue is empty, and whether memory writes are still outstanding. From these it keeps a registered busy flag. Software chooses one of two definitions of busy. When busy drops from 1 to 0, the block sets a sticky interrupt flag. An enable bit gates the interrupt output pin but never the stored flag.

Software uses a simple write and read port with two words. The control word holds the busy-mode select, the interrupt enable and a self-clearing interrupt-clear bit. The halt word holds a soft halt. The halt forces the engine's state machines idle and leaves every configuration field untouched.

Top module: `draw_status_ctrl`

## Requirements
- R1: After synchronous active-high reset, halt_o, busy_o and irq_o are 0, and both words read back as 0.
- R2: The control word stores the busy mode at bit 9 and the interrupt enable at bit 8, and both read back at those positions. Every other bit, the clear bit 10 included, reads 0. In the halt word only bit 0 is stored; bits 31:1 read 0 and writes to them are ignored.
- R3: Writing the halt word with bit 0 = 1 sets halt_o on the next edge. From the following edge busy_o is 0 whatever the status inputs are, and this forced drop raises no interrupt. Writing bit 0 = 0 releases the halt, after which busy follows the inputs again.
- R4: Writing the halt word leaves the busy mode and the interrupt enable unchanged.
- R5: In mode 0, busy_o rises one edge after eng_active is sampled high. A non-empty queue alone does not set busy. Once set, busy stays 1 while eng_active is 1, writes are pending or the queue is non-empty.
- R6: In mode 1, busy_o on each edge equals the OR of eng_active and a non-empty queue, as sampled at that edge.
- R7: On the edge where busy_o goes from 1 to 0 outside a halt, the interrupt flag is set, and it stays set until cleared.
- R8: A control-word write with bit 10 = 1 clears the flag on that edge. The clear acts once and is never stored.
- R9: If a flag set and a clear fall on the same edge, the flag ends up set.
- R10: irq_o is the flag ANDed with the enable. The flag keeps setting and holding while the enable is 0, so enabling it later shows a pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 halt word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 control word, 1 halt word |
| rd_data | output | 32 | Read data for the selected word (combinational) |
| eng_active | input | 1 | Draw state machine is running an operation |
| cmdq_empty | input | 1 | Command queue holds no entries |
| wr_pending | input | 1 | Memory writes still outstanding |
| halt_o | output | 1 | Soft halt to the engine state machines |
| busy_o | output | 1 | Engine busy flag |
| irq_o | output | 1 | Masked interrupt output |

## Verification
Two cases are hard to reach from the ports. The first is a busy fall that lands on the same edge as a software clear. The bench reaches it by lowering eng_active in the same cycle as it issues a control write with the clear bit set, then checks that irq_o reads 1 afterwards. The second is a busy drop forced by the halt. The bench keeps the engine active while it writes the halt, waits one more edge for the forced drop, and checks that no interrupt appears. It then reads back the control word to show the halt left the mode and enable untouched.

// File: rtl/draw_status_pkg.sv
package draw_status_pkg;

    localparam int WORD_W    = 32;
    localparam int POS_CLR   = 10;
    localparam int POS_MODE  = 9;
    localparam int POS_IEN   = 8;
    localparam int POS_HALT  = 0;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_HALT = 1'b1;

    typedef enum logic {
        BUSY_TRACK_OP = 1'b0,
        BUSY_OR_QUEUE = 1'b1
    } busy_mode_e;

    typedef struct packed {
        busy_mode_e mode;
        logic       irq_en;
    } ctrl_cfg_t;

    typedef struct packed {
        logic active;
        logic q_empty;
        logic pending;
    } eng_status_t;

    function automatic logic [WORD_W-1:0] ctrl_image(input ctrl_cfg_t c);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[POS_MODE] = c.mode;
        w[POS_IEN]  = c.irq_en;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] halt_image(input logic h);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[POS_HALT] = h;
        return w;
    endfunction

    function automatic logic mode_next(input busy_mode_e m,
                                       input logic busy_now,
                                       input eng_status_t s);
        logic r;
        if (m == BUSY_OR_QUEUE)
            r = s.active | ~s.q_empty;
        else if (busy_now)
            r = s.active | s.pending | ~s.q_empty;
        else
            r = s.active;
        return r;
    endfunction

endpackage

// File: rtl/draw_status_regs.sv
module draw_status_regs
    import draw_status_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output ctrl_cfg_t         cfg,
    output logic              halt,
    output logic              clr_pulse
);
    logic ctrl_wr;
    logic halt_wr;
    logic unused_rsv_bits;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign halt_wr = wr_en && (wr_sel == SEL_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '{mode: BUSY_TRACK_OP, irq_en: 1'b0};
            halt <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                cfg.mode   <= busy_mode_e'(wr_data[POS_MODE]);
                cfg.irq_en <= wr_data[POS_IEN];
            end
            if (halt_wr)
                halt <= wr_data[POS_HALT];
        end
    end

    assign clr_pulse = ctrl_wr && wr_data[POS_CLR];

    always_comb begin
        if (rd_sel == SEL_HALT)
            rd_data = DATA_W'(halt_image(halt));
        else
            rd_data = DATA_W'(ctrl_image(cfg));
    end

    assign unused_rsv_bits = ^wr_data;

endmodule

// File: rtl/draw_status_busy.sv
module draw_status_busy
    import draw_status_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  busy_mode_e  mode,
    input  logic        halt,
    input  eng_status_t status,
    output logic        busy,
    output logic        fall
);
    eng_status_t gated;
    logic        busy_nxt;

    always_comb begin
        gated        = status;
        gated.active = status.active & ~halt;
        busy_nxt     = halt ? 1'b0 : mode_next(mode, busy, gated);
    end

    assign fall = busy & ~busy_nxt & ~halt;

    always_ff @(posedge clk) begin
        if (rst)
            busy <= 1'b0;
        else
            busy <= busy_nxt;
    end

endmodule

// File: rtl/draw_status_irq.sv
module draw_status_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    input  logic enable,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end

    assign irq = flag & enable;

endmodule

// File: rtl/draw_status_ctrl.sv
module draw_status_ctrl
    import draw_status_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              eng_active,
    input  logic              cmdq_empty,
    input  logic              wr_pending,
    output logic              halt_o,
    output logic              busy_o,
    output logic              irq_o
);
    ctrl_cfg_t   cfg;
    eng_status_t status;
    logic        halt;
    logic        clr_pulse;
    logic        busy;
    logic        busy_fall;
    logic        irq_flag;

    assign status = '{active: eng_active, q_empty: cmdq_empty, pending: wr_pending};

    draw_status_regs #(.DATA_W(DATA_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .cfg       (cfg),
        .halt      (halt),
        .clr_pulse (clr_pulse)
    );

    draw_status_busy busy_i (
        .clk    (clk),
        .rst    (rst),
        .mode   (cfg.mode),
        .halt   (halt),
        .status (status),
        .busy   (busy),
        .fall   (busy_fall)
    );

    draw_status_irq irq_i (
        .clk     (clk),
        .rst     (rst),
        .set_req (busy_fall),
        .clr_req (clr_pulse),
        .enable  (cfg.irq_en),
        .flag    (irq_flag),
        .irq     (irq_o)
    );

    assign halt_o = halt;
    assign busy_o = busy;

endmodule

// File: rtl/draw_status_chk.sv
module draw_status_chk (
    input logic clk,
    input logic rst,
    input logic eng_active,
    input logic cmdq_empty,
    input logic halt_o,
    input logic busy_o,
    input logic irq_o,
    input logic irq_flag,
    input logic clr_pulse,
    input logic mode_q,
    input logic ien_q
);
    AST_HALT_FORCES_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(halt_o) |-> !busy_o); // R3

    AST_QUEUE_ALONE_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!$past(mode_q) && !$past(busy_o) && !$past(eng_active)) |-> !busy_o); // R5

    AST_OR_MODE_TRACKS: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) && !$past(halt_o)) |-> (busy_o == ($past(eng_active) || !$past(cmdq_empty)))); // R6

    AST_FALL_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && !$past(halt_o)) |-> irq_flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_flag) && !$past(clr_pulse)) |-> irq_flag); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_pulse) && !($fell(busy_o) && !$past(halt_o))) |-> !irq_flag); // R8

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_pulse) && $fell(busy_o) && !$past(halt_o)) |-> irq_flag); // R9

    AST_OUT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (irq_flag && ien_q)); // R10

    AST_MASK_OUT_ONLY: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && ien_q) |-> irq_o); // R10

endmodule

bind draw_status_ctrl draw_status_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .eng_active (eng_active),
    .cmdq_empty (cmdq_empty),
    .halt_o     (halt_o),
    .busy_o     (busy_o),
    .irq_o      (irq_o),
    .irq_flag   (irq_flag),
    .clr_pulse  (clr_pulse),
    .mode_q     (cfg.mode),
    .ien_q      (cfg.irq_en)
);

// File: tb/draw_status_ctrl_tb.sv
module draw_status_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        eng_active = 1'b0;
    logic        cmdq_empty = 1'b1;
    logic        wr_pending = 1'b0;
    logic        halt_o;
    logic        busy_o;
    logic        irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic  halt;
        logic  busy;
        logic  irq;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    always #10 clk = ~clk;

    draw_status_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .eng_active (eng_active),
        .cmdq_empty (cmdq_empty),
        .wr_pending (wr_pending),
        .halt_o     (halt_o),
        .busy_o     (busy_o),
        .irq_o      (irq_o)
    );

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            total++;
            if ({halt_o, busy_o, irq_o} !== {cur.halt, cur.busy, cur.irq}) begin
                bad++;
                $display("FAIL %s: halt/busy/irq actual=%b%b%b expected=%b%b%b",
                         cur.tag, halt_o, busy_o, irq_o, cur.halt, cur.busy, cur.irq);
            end
        end
    end

    task automatic cyc(input logic eh, input logic eb, input logic ei, input string tag);
        @(posedge clk);
        exp_q.push_back('{halt: eh, busy: eb, irq: ei, tag: tag});
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d,
                      input logic eh, input logic eb, input logic ei, input string tag);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
        cyc(eh, eb, ei, tag);
        wr_en   = 1'b0;
    endtask

    task automatic rdchk(input logic sel, input logic [31:0] e, input string tag);
        rd_sel = sel;
        #1;
        total++;
        if (rd_data !== e) begin
            bad++;
            $display("FAIL %s: rd_data actual=%h expected=%h", tag, rd_data, e);
        end
    endtask

    initial begin
        @(negedge clk);
        cyc(0, 0, 0, "R1 reset");
        cyc(0, 0, 0, "R1 reset");
        rdchk(0, 32'h0, "R1 ctrl reset");
        rdchk(1, 32'h0, "R1 halt reset");
        rst = 1'b0;

        wr(0, 32'hFFFF_FFFF, 0, 0, 0, "R2 write all ones");
        rdchk(0, 32'h0000_0300, "R2 ctrl readback");
        wr(0, 32'h0000_0100, 0, 0, 0, "R2 mode0 ien1");
        rdchk(0, 32'h0000_0100, "R2 ctrl readback");

        cmdq_empty = 1'b0;
        cyc(0, 0, 0, "R5 queue alone");
        eng_active = 1'b1;
        cyc(0, 1, 0, "R5 start op");
        eng_active = 1'b0;
        cyc(0, 1, 0, "R5 hold on queue");
        cmdq_empty = 1'b1; wr_pending = 1'b1;
        cyc(0, 1, 0, "R5 hold on pending");
        wr_pending = 1'b0;
        cyc(0, 0, 1, "R7 fall sets flag");

        wr(0, 32'h0000_0500, 0, 0, 0, "R8 clear");
        rdchk(0, 32'h0000_0100, "R8 clear bit reads 0");

        eng_active = 1'b1;
        cyc(0, 1, 0, "R9 busy");
        eng_active = 1'b0;
        wr(0, 32'h0000_0500, 0, 0, 1, "R9 set wins");
        wr(0, 32'h0000_0500, 0, 0, 0, "R8 clear again");

        wr(0, 32'h0000_0000, 0, 0, 0, "R10 disable");
        eng_active = 1'b1;
        cyc(0, 1, 0, "R10 busy");
        eng_active = 1'b0;
        cyc(0, 0, 0, "R10 masked");
        wr(0, 32'h0000_0100, 0, 0, 1, "R10 flag held");
        wr(0, 32'h0000_0500, 0, 0, 0, "R8 clear");

        wr(0, 32'h0000_0300, 0, 0, 0, "R6 mode1");
        cmdq_empty = 1'b0;
        cyc(0, 1, 0, "R6 queue busy");
        cmdq_empty = 1'b1;
        cyc(0, 0, 1, "R6 queue drained");
        wr(0, 32'h0000_0700, 0, 0, 0, "R8 clear mode1");
        eng_active = 1'b1;
        cyc(0, 1, 0, "R6 active busy");
        eng_active = 1'b0;
        cyc(0, 0, 1, "R6 idle");
        wr(0, 32'h0000_0700, 0, 0, 0, "R8 clear mode1");

        eng_active = 1'b1;
        cyc(0, 1, 0, "R3 busy");
        wr(1, 32'h0000_0001, 1, 1, 0, "R3 halt set");
        cyc(1, 0, 0, "R3 forced idle no irq");
        cmdq_empty = 1'b0;
        cyc(1, 0, 0, "R3 inputs ignored");
        rdchk(1, 32'h0000_0001, "R3 halt readback");
        rdchk(0, 32'h0000_0300, "R4 ctrl kept");
        eng_active = 1'b0; cmdq_empty = 1'b1;
        wr(1, 32'h0000_0000, 0, 0, 0, "R3 release");
        eng_active = 1'b1;
        cyc(0, 1, 0, "R3 resume");
        eng_active = 1'b0;
        cyc(0, 0, 1, "R7 fall after release");

        wr(1, 32'hFFFF_FFFE, 0, 0, 1, "R2 halt reserved");
        rdchk(1, 32'h0, "R2 halt reserved ignored");

        @(posedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule